// File: doc/BRIEF.md
# Predicated Instruction Bundle Unpacker

This block takes a 128-bit instruction bundle and emits its three instruction slots one after another, oldest first. A bundle holds a 5-bit template and three 41-bit slots. Each emitted slot carries its position in the bundle and the bundle's template, which passes through unchanged. The low 6 bits of every slot name the predicate register that qualifies it. The block reads that register from a 64-entry, 1-bit predicate file. When the register reads 0, the slot still leaves the block, with its kill flag set, so that downstream units see every slot in its original position.

Compare and test operations update the predicate file through several write ports in the same cycle, because one compare can set more than one predicate. A write lands in the same cycle that a slot naming that register is presented, and the kill flag then follows the written value. Predicate register 0 always reads 1, and writes to it change nothing.

A four-state machine sequences the work. In `ST_IDLE` the input is ready. An accepted bundle moves the machine to `ST_SLOT0`, and each output handshake steps it to `ST_SLOT1`, then `ST_SLOT2`. From `ST_SLOT2` a completed handshake returns to `ST_IDLE`. If a new bundle is offered in that same cycle, the machine goes straight back to `ST_SLOT0`, so that back-to-back bundles stream one slot per cycle with no gap.

Top module: `bundle_unpack`

## Requirements
- R1: Field layout: the template is bundle bits 4:0, slot 0 is bits 45:5, slot 1 is bits 86:46 and slot 2 is bits 127:87. `out_tmpl` shows the accepted bundle's template, unchanged, with every slot.
- R2: `in_ready` is 1 only in `ST_IDLE`, or while slot 2 is presented with `out_ready` at 1. A bundle is taken on a clock edge where `in_valid` and `in_ready` are both 1.
- R3: After a bundle is taken, `out_valid` rises on the next cycle with `out_idx` = 0. Each output handshake advances `out_idx` to 1 and then to 2. A bundle taken during the final handshake of the previous one has its slot 0 presented on the very next cycle.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_idx`, `out_slot` and `out_tmpl` hold their values.
- R5: `out_kill` is the inverse of the predicate register named by `out_slot[5:0]`.
- R6: Predicate register 0 always reads 1, so a slot naming it is never killed. A write to register 0 has no effect.
- R7: A write to register n with value v makes register n read v from the following cycle on. In the cycle of the write itself, a presented slot naming n already sees v.
- R8: All write ports (`pw_en` bit w, `pw_idx` bits 6w+5:6w, `pw_val` bit w) act in the same cycle. When several ports name the same register, the highest-numbered port wins, both for the stored value and for the forwarded value.
- R9: After reset `in_ready` is 1, `out_valid` is 0, and predicate registers 1 to 63 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Bundle can be taken |
| in_bundle | input | 128 | Template and three slots |
| out_valid | output | 1 | Slot presented |
| out_ready | input | 1 | Consumer takes the slot |
| out_idx | output | 2 | Position of the slot in its bundle |
| out_tmpl | output | 5 | Template of the bundle |
| out_slot | output | 41 | Instruction slot |
| out_kill | output | 1 | Qualifying predicate is false |
| pw_en | input | 2 | Per-port predicate write enable |
| pw_idx | input | 12 | Per-port predicate register number, 6 bits each |
| pw_val | input | 2 | Per-port predicate value |

## Verification
The hardest case to reach is a predicate write that coincides with a slot naming the same register, particularly when both write ports name that register. The stimulus gets there by stalling the consumer so that the slot stays presented, and then driving both ports in that stalled cycle. The flag is checked before the edge and again after it. Full sweeps over all 64 predicate numbers, under two written patterns, cover the lookup. Streams run under steady and intermittent `out_ready` cover ordering, holding and back-to-back acceptance.

// File: rtl/bundle_unpack_pkg.sv
package bundle_unpack_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SLOT0 = 2'd1,
        ST_SLOT1 = 2'd2,
        ST_SLOT2 = 2'd3
    } unpack_state_e;
endpackage

// File: rtl/pred_file.sv
module pred_file #(
    parameter int PRED_N = 64,
    parameter int NWR    = 2,
    localparam int PIDX_W = $clog2(PRED_N)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NWR-1:0]        wr_en,
    input  logic [NWR*PIDX_W-1:0] wr_idx,
    input  logic [NWR-1:0]        wr_val,
    input  logic [PIDX_W-1:0]     rd_idx,
    output logic                  rd_val
);
    logic [PRED_N-1:0] bits_q;

    // higher port index overrides lower ones; register 0 never stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            for (int w = 0; w < NWR; w++) begin
                if (wr_en[w] && wr_idx[w*PIDX_W +: PIDX_W] != '0)
                    bits_q[wr_idx[w*PIDX_W +: PIDX_W]] <= wr_val[w];
            end
        end
    end

    // read with same-cycle forwarding, last matching port wins
    always_comb begin
        rd_val = bits_q[rd_idx];
        for (int w = 0; w < NWR; w++) begin
            if (wr_en[w] && wr_idx[w*PIDX_W +: PIDX_W] == rd_idx)
                rd_val = wr_val[w];
        end
        if (rd_idx == '0)
            rd_val = 1'b1;
    end

    AST_TOP_PORT_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[NWR-1] && wr_idx[(NWR-1)*PIDX_W +: PIDX_W] != '0)
        |=> bits_q[$past(wr_idx[(NWR-1)*PIDX_W +: PIDX_W])] == $past(wr_val[NWR-1])); // R8
    AST_FWD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[NWR-1] && wr_idx[(NWR-1)*PIDX_W +: PIDX_W] == rd_idx && rd_idx != '0)
        |=> bits_q[$past(rd_idx)] == $past(rd_val)); // R7
endmodule

// File: rtl/slot_pick.sv
module slot_pick #(
    parameter int TMPL_W = 5,
    parameter int SLOT_W = 41,
    parameter int NSLOT  = 3,
    localparam int BUN_W = TMPL_W + NSLOT * SLOT_W,
    localparam int SEL_W = $clog2(NSLOT)
) (
    input  logic [BUN_W-1:0]  bundle,
    input  logic [SEL_W-1:0]  sel,
    output logic [TMPL_W-1:0] tmpl,
    output logic [SLOT_W-1:0] slot
);
    logic [SLOT_W-1:0] lanes [NSLOT];

    for (genvar s = 0; s < NSLOT; s++) begin : g_lane
        assign lanes[s] = bundle[TMPL_W + s*SLOT_W +: SLOT_W];
    end

    assign tmpl = bundle[TMPL_W-1:0];

    always_comb begin
        slot = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (SEL_W'(s) == sel)
                slot = lanes[s];
        end
    end
endmodule

// File: rtl/bundle_unpack.sv
module bundle_unpack
    import bundle_unpack_pkg::*;
#(
    parameter int TMPL_W = 5,
    parameter int SLOT_W = 41,
    parameter int PRED_N = 64,
    parameter int NWR    = 2,
    localparam int NSLOT  = 3,
    localparam int BUN_W  = TMPL_W + NSLOT * SLOT_W,
    localparam int PIDX_W = $clog2(PRED_N),
    localparam int SEL_W  = $clog2(NSLOT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [BUN_W-1:0]      in_bundle,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [SEL_W-1:0]      out_idx,
    output logic [TMPL_W-1:0]     out_tmpl,
    output logic [SLOT_W-1:0]     out_slot,
    output logic                  out_kill,
    input  logic [NWR-1:0]        pw_en,
    input  logic [NWR*PIDX_W-1:0] pw_idx,
    input  logic [NWR-1:0]        pw_val
);
    unpack_state_e state_q, state_d;
    logic [BUN_W-1:0] bundle_q;
    logic             take;
    logic             pred_bit;

    assign take = in_valid && in_ready;

    // state register and bundle capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bundle_q <= '0;
        end else begin
            state_q <= state_d;
            if (take)
                bundle_q <= in_bundle;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid) state_d = ST_SLOT0;
            ST_SLOT0: if (out_ready) state_d = ST_SLOT1;
            ST_SLOT1: if (out_ready) state_d = ST_SLOT2;
            ST_SLOT2: if (out_ready) state_d = in_valid ? ST_SLOT0 : ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_idx   = '0;
        unique case (state_q)
            ST_IDLE:  in_ready = 1'b1;
            ST_SLOT0: begin out_valid = 1'b1; out_idx = SEL_W'(0); end
            ST_SLOT1: begin out_valid = 1'b1; out_idx = SEL_W'(1); end
            ST_SLOT2: begin out_valid = 1'b1; out_idx = SEL_W'(2); in_ready = out_ready; end
        endcase
    end

    slot_pick #(.TMPL_W(TMPL_W), .SLOT_W(SLOT_W), .NSLOT(NSLOT)) u_pick (
        .bundle (bundle_q),
        .sel    (out_idx),
        .tmpl   (out_tmpl),
        .slot   (out_slot)
    );

    pred_file #(.PRED_N(PRED_N), .NWR(NWR)) u_preds (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (pw_en),
        .wr_idx (pw_idx),
        .wr_val (pw_val),
        .rd_idx (out_slot[PIDX_W-1:0]),
        .rd_val (pred_bit)
    );

    assign out_kill = out_valid && !pred_bit;

    AST_P0_NEVER_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_slot[PIDX_W-1:0] == '0) |-> !out_kill); // R6
    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) && $stable(out_slot) && $stable(out_tmpl))); // R4
    AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_idx != SEL_W'(2)) |=> (out_valid && out_idx == SEL_W'($past(out_idx) + 1'b1))); // R3
    AST_ACCEPT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!out_valid || (out_idx == SEL_W'(2) && out_ready))); // R2
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_idx == '0)); // R3
endmodule

// File: tb/test_bundle_unpack.sv
module test_bundle_unpack;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_bundle = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [1:0]   out_idx;
    logic [4:0]   out_tmpl;
    logic [40:0]  out_slot;
    logic         out_kill;
    logic [1:0]   pw_en = '0;
    logic [11:0]  pw_idx = '0;
    logic [1:0]   pw_val = '0;

    int checks = 0;
    int errors = 0;
    logic model [64];
    logic [127:0] bq [32];
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bundle_unpack i_bundle_unpack (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_bundle(in_bundle), .out_valid(out_valid), .out_ready(out_ready),
        .out_idx(out_idx), .out_tmpl(out_tmpl), .out_slot(out_slot),
        .out_kill(out_kill), .pw_en(pw_en), .pw_idx(pw_idx), .pw_val(pw_val)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [40:0] mk_slot(input int seed, input int p);
        logic [34:0] body;
        body = 35'(seed * 32'h9E3779B1 + 32'h1234567);
        return {body, 6'(p)};
    endfunction

    function automatic logic [127:0] mk_bundle(input int seed, input int p0, input int p1, input int p2);
        return {mk_slot(seed*3+2, p2), mk_slot(seed*3+1, p1), mk_slot(seed*3, p0), 5'(seed*7+3)};
    endfunction

    // checks all outputs for slot k of bundle b
    task automatic chk_slot(input logic [127:0] b, input int k, input string req);
        logic [40:0] es;
        es = b[5 + k*41 +: 41];
        chk({req, " R3 valid"}, 64'(out_valid), 64'(1));
        chk({req, " R3 idx"}, 64'(out_idx), 64'(k));
        chk({req, " R1 slot"}, 64'(out_slot), 64'(es));
        chk({req, " R1 tmpl"}, 64'(out_tmpl), 64'(b[4:0]));
        chk({req, " R5 kill"}, 64'(out_kill), 64'(!model[es[5:0]]));
    endtask

    // stream nb bundles from bq; mode 0 always ready, else stalls
    task automatic run_stream(input int nb, input int mode, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_bundle = bq[0];
        #1 chk("R2 idle ready", 64'(in_ready), 64'(1));
        @(posedge clk);
        for (int j = 0; j < nb; j++) begin
            for (int k = 0; k < 3; k++) begin
                logic rdy;
                logic stalled;
                stalled = 1'b1;
                while (stalled) begin
                    @(negedge clk);
                    rdy = (mode == 0) ? 1'b1 : ((cyc * 5 + 3) % mode != 0);
                    out_ready = rdy;
                    in_valid = (k == 2 && rdy && j + 1 < nb);
                    if (in_valid) in_bundle = bq[j+1];
                    #1;
                    chk_slot(bq[j], k, rdy ? req : {req, " R4 stall"});
                    chk("R2 ready gate", 64'(in_ready), 64'(k == 2 && rdy));
                    @(posedge clk);
                    stalled = !rdy;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b0;
        #1 chk("R3 drained", 64'(out_valid), 64'(0));
    endtask

    task automatic wr2(input logic e0, input int i0, input logic v0,
                       input logic e1, input int i1, input logic v1);
        @(negedge clk);
        pw_en = {e1, e0}; pw_idx = {6'(i1), 6'(i0)}; pw_val = {v1, v0};
        @(posedge clk);
        if (e0 && i0 != 0) model[i0] = v0;
        if (e1 && i1 != 0) model[i1] = v1;
        @(negedge clk);
        pw_en = '0;
    endtask

    task automatic sweep_all(input int mode, input string req);
        for (int j = 0; j < 22; j++)
            bq[j] = mk_bundle(j + mode * 50, (3*j) % 64, (3*j+1) % 64, (3*j+2) % 64);
        run_stream(22, mode, req);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) model[i] = (i == 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R9 reset in_ready", 64'(in_ready), 64'(1));
        chk("R9 reset out_valid", 64'(out_valid), 64'(0));

        // R9 R6: all registers after reset
        sweep_all(0, "R9 sweep");

        // pattern A through both ports
        for (int i = 0; i < 64; i += 2)
            wr2(1'b1, i, ((i*37+11) >> 2) & 1, 1'b1, i+1, (((i+1)*37+11) >> 2) & 1);
        sweep_all(4, "R7 pattern A");

        // R6: write 0 to register 0, then read it
        wr2(1'b1, 0, 1'b0, 1'b1, 0, 1'b0);
        bq[0] = mk_bundle(900, 0, 0, 0);
        run_stream(1, 0, "R6 p0");

        // R8 conflict: both ports on one register, higher port wins
        wr2(1'b1, 17, 1'b1, 1'b1, 17, 1'b0);
        chk("R8 model", 64'(model[17]), 64'(0));
        wr2(1'b1, 18, 1'b0, 1'b1, 18, 1'b1);
        bq[0] = mk_bundle(901, 17, 18, 5);
        run_stream(1, 3, "R8 conflict");

        // pattern B inverse
        for (int i = 0; i < 64; i += 2)
            wr2(1'b1, i, !model[i], 1'b1, i+1, !model[i+1]);
        sweep_all(3, "R7 pattern B");

        // R7 forward: write during a stalled presentation
        for (int t = 0; t < 4; t++) begin
            int p;
            logic nv;
            p = 20 + t;
            nv = !model[p];
            bq[0] = mk_bundle(950 + t, p, 0, p);
            @(negedge clk);
            in_valid = 1'b1; in_bundle = bq[0];
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0; out_ready = 1'b0;
            if (t < 2) begin
                pw_en = 2'b01; pw_idx = {6'd0, 6'(p)}; pw_val = {1'b0, nv};
            end else begin
                pw_en = 2'b11; pw_idx = {6'(p), 6'(p)}; pw_val = {nv, !nv};
            end
            #1;
            chk(t < 2 ? "R7 forward kill" : "R8 forward kill", 64'(out_kill), 64'(!nv));
            @(posedge clk);
            model[p] = nv;
            @(negedge clk);
            pw_en = '0;
            #1 chk_slot(bq[0], 0, "R7 after write");
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                out_ready = 1'b1;
                #1 chk_slot(bq[0], k, "R7 finish");
                @(posedge clk);
            end
            @(negedge clk);
            out_ready = 1'b0;
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule